// File: doc/BRIEF.md
# Multi-mode conversion sequencer

This block decides which of sixteen result/control slots each analog conversion uses. It also decides when the next conversion may begin. It sits between a sample-timing controller and the result memory. The timing controller reports a trigger edge as a one-cycle `trig_i` pulse and the end of each conversion as a `conv_done_i` pulse. The sequencer answers with a slot pointer, which selects the channel and reference for the conversion. It also gives a one-hot write-enable into the result memory and a request to start the next conversion.

Four operating modes are available:

- one conversion of one slot;
- one pass through a run of slots that ends at a marked slot;
- repeated conversion of one slot;
- repeated passes through a run of slots.

A chaining option starts each next conversion of a run as soon as the previous one finishes, with no new trigger. Stopping on a cleared enable depends on the mode. Per-slot result flags track unread results, and an overflow strobe reports a result that lands on an unread slot.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset `busy_o` is 0, `slot_o` is 0, `flags_o` is all zero and no write-enable is raised.
- R2: With `mode_i` = 2'b00 (single slot, once), an accepted trigger loads `slot_o` with `start_slot_i` and raises `conv_req_o` in the trigger cycle. The next `conv_done_i` raises only bit `start_slot_i` of `wr_en_o`, and the block then returns to idle (`busy_o` = 0).
- R3: With `mode_i` = 2'b01 (run, once), the slot starts at `start_slot_i` and steps up by one after each completed conversion, wrapping from 15 to 0. The run ends, with `busy_o` falling, after the write to the slot whose bit in `eos_i` is 1.
- R4: With `mode_i` = 2'b11 (run, repeated), after the write to the end-marked slot `slot_o` returns to `start_slot_i` and `busy_o` stays 1. The next trigger begins a new pass.
- R5: With `mode_i` = 2'b10 (single slot, repeated), every conversion writes slot `start_slot_i`. Clearing `enable_i` lets the conversion in progress finish and write, then the block goes idle.
- R6: With `chain_i` = 1 in a mode other than 2'b00, `conv_req_o` is raised in the same cycle as the `conv_done_i` of every conversion that is not the last of a run. Trigger pulses that arrive while a conversion is running are ignored and do not move `slot_o`.
- R7: With `soft_trig_i` = 0 in modes 2'b00 and 2'b01, a trigger after a finished conversion or run is refused until `enable_i` has been 0 for at least one cycle. With `soft_trig_i` = 1, back-to-back triggers are accepted without that toggle.
- R8: In modes 2'b01 and 2'b11, clearing `enable_i` does not stop a run before its end-marked slot. If no `eos_i` bit is set, conversions go on.
- R9: Setting `mode_i` to 2'b00 while `enable_i` is 0 stops any mode at once: a `conv_done_i` in that cycle writes nothing, and `busy_o` is 0 on the next cycle.
- R10: A write to slot x sets `flags_o[x]`. A read strobe (`rd_en_i` with `rd_slot_i` = x) clears it.
- R11: `ovf_o` pulses together with a write to a slot whose flag is still set.
- R12: While idle with `enable_i` = 0, a trigger starts nothing: `conv_req_o` stays 0 and `busy_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Conversion enable; configuration may change only while 0 |
| mode_i | input | 2 | 00 single once, 01 run once, 10 single repeated, 11 run repeated |
| start_slot_i | input | 4 | First slot, or the only slot in single modes |
| eos_i | input | 16 | One end-of-run mark per slot |
| chain_i | input | 1 | Chain conversions back to back without triggers |
| soft_trig_i | input | 1 | 1 when triggers come from software, 0 for a hardware source |
| trig_i | input | 1 | One-cycle trigger edge from the timing controller |
| conv_done_i | input | 1 | One-cycle conversion-complete strobe |
| rd_en_i | input | 1 | Result read strobe |
| rd_slot_i | input | 4 | Slot being read |
| slot_o | output | 4 | Current slot pointer |
| conv_req_o | output | 1 | Start a sample and conversion now |
| wr_en_o | output | 16 | One-hot result write-enable |
| flags_o | output | 16 | Per-slot unread-result flags |
| busy_o | output | 1 | A conversion or run is active |
| ovf_o | output | 1 | Result written over an unread one |

## Verification
The bench runs a single-pass run that starts at slot 14 and ends at slot 1. A pointer that saturates or fails to wrap would write slot 15 twice or go past the mark. In chained repeat mode the bench sends a stray trigger in the middle of a conversion. A design that honoured it would issue an extra request or skip a slot. It also clears enable in the middle of a run and checks that the run still finishes; a design that stopped at once would drop the last slot. The bench checks that a hardware-triggered restart is refused without an enable toggle, and that a forced stop with `mode_i` = 00 discards a result that arrives at the same cycle. Rewriting unread slots must raise `ovf_o`.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int SLOTS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable_i,
  input  logic [1:0]               mode_i,
  input  logic [$clog2(SLOTS)-1:0] start_slot_i,
  input  logic [SLOTS-1:0]         eos_i,
  input  logic                     chain_i,
  input  logic                     soft_trig_i,
  input  logic                     trig_i,
  input  logic                     conv_done_i,
  input  logic                     rd_en_i,
  input  logic [$clog2(SLOTS)-1:0] rd_slot_i,
  output logic [$clog2(SLOTS)-1:0] slot_o,
  output logic                     conv_req_o,
  output logic [SLOTS-1:0]         wr_en_o,
  output logic [SLOTS-1:0]         flags_o,
  output logic                     busy_o,
  output logic                     ovf_o
);
  localparam int PW = $clog2(SLOTS);

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_WAIT} st_t;

  st_t           st, st_n;
  logic [PW-1:0] ptr, ptr_n;
  logic          head, head_n;
  logic          armed;
  logic          start_ev, done_ev;
  logic [SLOTS-1:0] rd_mask;

  wire           kill    = (mode_i == 2'b00) && !enable_i;
  wire           last    = mode_i[0] ? eos_i[ptr] : 1'b1;
  wire [PW-1:0]  ptr_inc = (ptr == PW'(SLOTS - 1)) ? '0 : ptr + 1'b1;

  always_comb begin
    st_n     = st;
    ptr_n    = ptr;
    head_n   = head;
    start_ev = 1'b0;
    done_ev  = 1'b0;
    case (st)
      S_IDLE: begin
        if (trig_i && enable_i && armed) begin
          start_ev = 1'b1;
          st_n     = S_CONV;
          ptr_n    = start_slot_i;
          head_n   = 1'b0;
        end
      end
      S_WAIT: begin
        if (kill || (!enable_i && (head || mode_i == 2'b10)))
          st_n = S_IDLE;
        else if (trig_i) begin
          start_ev = 1'b1;
          st_n     = S_CONV;
          head_n   = 1'b0;
        end
      end
      S_CONV: begin
        if (kill)
          st_n = S_IDLE;
        else if (conv_done_i) begin
          done_ev = 1'b1;
          case (mode_i)
            2'b00: st_n = S_IDLE;
            2'b01: begin
              if (last) st_n = S_IDLE;
              else begin
                ptr_n  = ptr_inc;
                st_n   = chain_i ? S_CONV : S_WAIT;
                head_n = 1'b0;
              end
            end
            2'b10: begin
              if (!enable_i) st_n = S_IDLE;
              else begin
                st_n   = chain_i ? S_CONV : S_WAIT;
                head_n = 1'b1;
              end
            end
            default: begin
              if (last) begin
                if (!enable_i) st_n = S_IDLE;
                else begin
                  ptr_n  = start_slot_i;
                  st_n   = S_WAIT;
                  head_n = 1'b1;
                end
              end else begin
                ptr_n  = ptr_inc;
                st_n   = chain_i ? S_CONV : S_WAIT;
                head_n = 1'b0;
              end
            end
          endcase
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ptr     <= '0;
      head    <= 1'b0;
      armed   <= 1'b0;
      flags_o <= '0;
    end else begin
      st      <= st_n;
      ptr     <= ptr_n;
      head    <= head_n;
      flags_o <= (flags_o & ~rd_mask) | wr_en_o;
      if (!enable_i)
        armed <= 1'b1;
      else if (done_ev && st_n == S_IDLE && !soft_trig_i)
        armed <= 1'b0;
    end
  end

  assign rd_mask    = rd_en_i ? (SLOTS'(1) << rd_slot_i) : '0;
  assign wr_en_o    = done_ev ? (SLOTS'(1) << ptr) : '0;
  assign ovf_o      = |(wr_en_o & flags_o & ~rd_mask);
  assign conv_req_o = start_ev || (done_ev && st_n == S_CONV);
  assign busy_o     = (st != S_IDLE);
  assign slot_o     = ptr;

  assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_en_o) |=> ((flags_o & $past(wr_en_o)) == $past(wr_en_o)));

  assert_single_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|wr_en_o) && mode_i == 2'b00) |=> !busy_o);

  assert_ovf_needs_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (|wr_en_o));

  assert_slot_moves_on_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && (slot_o != $past(slot_o))) |-> $past(conv_done_i));

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && mode_i == 2'b00 && !enable_i) |=> !busy_o);

  assert_no_start_disabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !enable_i) |-> !conv_req_o);
endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [3:0]  start_slot_i = '0;
  logic [15:0] eos_i = '0;
  logic        chain_i = 1'b0;
  logic        soft_trig_i = 1'b0;
  logic        trig_i = 1'b0;
  logic        conv_done_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [3:0]  rd_slot_i = '0;
  logic [3:0]  slot_o;
  logic        conv_req_o;
  logic [15:0] wr_en_o;
  logic [15:0] flags_o;
  logic        busy_o;
  logic        ovf_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .mode_i(mode_i),
    .start_slot_i(start_slot_i), .eos_i(eos_i), .chain_i(chain_i),
    .soft_trig_i(soft_trig_i), .trig_i(trig_i), .conv_done_i(conv_done_i),
    .rd_en_i(rd_en_i), .rd_slot_i(rd_slot_i), .slot_o(slot_o),
    .conv_req_o(conv_req_o), .wr_en_o(wr_en_o), .flags_o(flags_o),
    .busy_o(busy_o), .ovf_o(ovf_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setup(input logic [1:0] m, input logic [3:0] s, input logic [15:0] e,
                       input logic ch, input logic sw);
    @(negedge clk);
    enable_i = 1'b0;
    mode_i = m; start_slot_i = s; eos_i = e; chain_i = ch; soft_trig_i = sw;
    @(negedge clk);
    enable_i = 1'b1;
  endtask

  task automatic trig(input logic exp_req, input string tag);
    @(negedge clk);
    trig_i = 1'b1;
    #1 chk(conv_req_o == exp_req, tag, conv_req_o, exp_req);
    @(negedge clk);
    trig_i = 1'b0;
  endtask

  task automatic done(input logic [15:0] exp_wr, input logic exp_req, input logic exp_ovf, input string tag);
    @(negedge clk);
    conv_done_i = 1'b1;
    #1;
    chk(wr_en_o == exp_wr, {tag, " wr"}, wr_en_o, exp_wr);
    chk(conv_req_o == exp_req, {tag, " req"}, conv_req_o, exp_req);
    chk(ovf_o == exp_ovf, {tag, " ovf"}, ovf_o, exp_ovf);
    @(negedge clk);
    conv_done_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] s);
    @(negedge clk);
    rd_en_i = 1'b1; rd_slot_i = s;
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  task automatic t_reset;
    chk(busy_o == 1'b0, "R1 busy", busy_o, 0);
    chk(slot_o == 4'd0, "R1 slot", slot_o, 0);
    chk(flags_o == 16'h0, "R1 flags", flags_o, 0);
    chk(wr_en_o == 16'h0, "R1 wr", wr_en_o, 0);
  endtask

  task automatic t_single;
    setup(2'b00, 4'd5, 16'h0, 1'b0, 1'b0);
    trig(1'b1, "R2 start");
    chk(busy_o && slot_o == 4'd5, "R2 slot", slot_o, 5);
    done(16'h0020, 1'b0, 1'b0, "R2 done");
    chk(busy_o == 1'b0, "R2 idle", busy_o, 0);
    chk(flags_o == 16'h0020, "R10 flag set", flags_o, 16'h0020);
    trig(1'b0, "R7 hw retrigger refused");
    chk(busy_o == 1'b0, "R7 stays idle", busy_o, 0);
    rd(4'd5);
    chk(flags_o == 16'h0, "R10 read clears", flags_o, 0);
    setup(2'b00, 4'd9, 16'h0, 1'b0, 1'b1);
    trig(1'b1, "R7 soft first");
    done(16'h0200, 1'b0, 1'b0, "R7 soft first done");
    trig(1'b1, "R7 soft second without toggle");
    done(16'h0200, 1'b0, 1'b1, "R11 rewrite unread");
    rd(4'd9);
  endtask

  task automatic t_seq_once;
    setup(2'b01, 4'd14, 16'h0002, 1'b0, 1'b0);
    trig(1'b1, "R3 start");
    chk(slot_o == 4'd14, "R3 first slot", slot_o, 14);
    done(16'h4000, 1'b0, 1'b0, "R3 slot14");
    chk(busy_o && slot_o == 4'd15, "R3 step", slot_o, 15);
    trig(1'b1, "R3 trig2");
    done(16'h8000, 1'b0, 1'b0, "R3 slot15");
    chk(slot_o == 4'd0, "R3 wrap", slot_o, 0);
    trig(1'b1, "R3 trig3");
    done(16'h0001, 1'b0, 1'b0, "R3 slot0");
    chk(slot_o == 4'd1, "R3 step to 1", slot_o, 1);
    trig(1'b1, "R3 trig4");
    done(16'h0002, 1'b0, 1'b0, "R3 slot1");
    chk(busy_o == 1'b0, "R3 ends at mark", busy_o, 0);
    chk(flags_o == 16'hC003, "R10 run flags", flags_o, 16'hC003);
    trig(1'b0, "R7 run retrigger refused");
    setup(2'b01, 4'd14, 16'h0002, 1'b0, 1'b0);
    trig(1'b1, "R7 accepted after toggle");
    done(16'h4000, 1'b0, 1'b1, "R11 overflow slot14");
    @(negedge clk);
    enable_i = 1'b0; mode_i = 2'b00;
    @(negedge clk);
    chk(busy_o == 1'b0, "R9 abort waiting run", busy_o, 0);
    rd(4'd14); rd(4'd15); rd(4'd0); rd(4'd1);
    chk(flags_o == 16'h0, "R10 all cleared", flags_o, 0);
  endtask

  task automatic t_chain_repeat;
    setup(2'b11, 4'd2, 16'h0008, 1'b1, 1'b1);
    trig(1'b1, "R4 start");
    chk(slot_o == 4'd2, "R4 first", slot_o, 2);
    done(16'h0004, 1'b1, 1'b0, "R6 chained");
    chk(slot_o == 4'd3, "R6 next slot", slot_o, 3);
    trig(1'b0, "R6 stray trigger ignored");
    chk(slot_o == 4'd3, "R6 slot held", slot_o, 3);
    done(16'h0008, 1'b0, 1'b0, "R4 end of pass");
    chk(busy_o && slot_o == 4'd2, "R4 reload", slot_o, 2);
    trig(1'b1, "R4 new pass");
    @(negedge clk);
    enable_i = 1'b0;
    done(16'h0004, 1'b1, 1'b1, "R8 run continues");
    chk(busy_o && slot_o == 4'd3, "R8 still busy", busy_o, 1);
    done(16'h0008, 1'b0, 1'b1, "R8 last slot");
    chk(busy_o == 1'b0, "R8 stops at end", busy_o, 0);
    rd(4'd2); rd(4'd3);
  endtask

  task automatic t_repeat_single;
    setup(2'b10, 4'd7, 16'h0, 1'b0, 1'b0);
    trig(1'b1, "R5 start");
    done(16'h0080, 1'b0, 1'b0, "R5 first");
    chk(busy_o && slot_o == 4'd7, "R5 waits", slot_o, 7);
    trig(1'b1, "R5 retrigger");
    done(16'h0080, 1'b0, 1'b1, "R11 repeat overflow");
    trig(1'b1, "R5 third");
    @(negedge clk);
    enable_i = 1'b0;
    done(16'h0080, 1'b0, 1'b1, "R5 finishes current");
    chk(busy_o == 1'b0, "R5 stopped", busy_o, 0);
    rd(4'd7);
  endtask

  task automatic t_no_mark;
    setup(2'b01, 4'd15, 16'h0, 1'b1, 1'b1);
    trig(1'b1, "R8 start");
    done(16'h8000, 1'b1, 1'b0, "R8 slot15");
    @(negedge clk);
    enable_i = 1'b0;
    done(16'h0001, 1'b1, 1'b0, "R8 unmarked keeps going");
    chk(busy_o && slot_o == 4'd1, "R8 no stop", slot_o, 1);
    @(negedge clk);
    mode_i = 2'b00; conv_done_i = 1'b1;
    #1 chk(wr_en_o == 16'h0, "R9 no write on abort", wr_en_o, 0);
    @(negedge clk);
    conv_done_i = 1'b0;
    chk(busy_o == 1'b0, "R9 immediate stop", busy_o, 0);
    rd(4'd15); rd(4'd0);
  endtask

  task automatic t_disabled;
    @(negedge clk);
    enable_i = 1'b0; mode_i = 2'b01; soft_trig_i = 1'b1;
    trig(1'b0, "R12 no start when disabled");
    chk(busy_o == 1'b0, "R12 idle", busy_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_seq_once();
    t_chain_repeat();
    t_repeat_single();
    t_no_mark();
    t_disabled();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule